// File: doc/BRIEF.md
# Operand-Pair Result-Bank Processor Core

This is a small non-pipelined processor core. It has no general arithmetic opcode and no destination register. Two operand registers, A and B, feed a result bank that holds their sum, the right shift of A by B, and an unsigned greater-than flag. All three results exist at all times. An instruction loads A or B from data RAM, stores one named result to a RAM address, handles the staging register C, or changes the program counter.

Each instruction is one 24-bit word. The word comes combinationally from a read-only program memory, indexed by the program counter. Every instruction takes two clock cycles. In the issue cycle, the core latches the word and presents its operand field as the data-RAM address, so a synchronous RAM returns the addressed word in the next cycle. In the execute cycle, the core captures a loaded value, drives a write, or selects the next program counter. A halt instruction freezes the core until reset and raises a status output.

Top module: `opbank_core`

## Requirements
- R1: While reset is asserted and after it is released, the program counter, A, B and C read as zero, `halted` is low and `dmem_we` is low. A store of the sum, of C or of the shift issued first after reset writes 0.
- R2: An instruction word has the opcode in bits 23:18 and the operand field in bits 17:0. Each instruction holds `imem_addr` for exactly two clock cycles. A non-branching instruction advances it by one, and at most one data write happens per instruction.
- R3: Opcode 0x01 loads A and opcode 0x02 loads B with the data-RAM word at the low address bits of the operand field.
- R4: Opcode 0x03 loads C with the low DATA_W bits of the operand field. Opcode 0x04 writes C to the operand address.
- R5: Opcode 0x05 writes A+B, taken modulo 2^DATA_W, to the operand address.
- R6: Opcode 0x06 writes A logically shifted right by B positions to the operand address. A shift amount of DATA_W or more gives zero.
- R7: Opcode 0x07 loads the program counter with the low bits of the operand field.
- R8: Opcode 0x08 loads the program counter with the operand only when A > B, compared unsigned. When A equals or is below B, execution continues at the next address.
- R9: Opcode 0x3F raises `halted`. After that the program counter is frozen, no further write occurs, and `halted` stays high until reset.
- R10: Any other opcode leaves A, B, C and RAM unchanged and advances to the next instruction.
- R11: A Fibonacci loop made of these instructions, seeded with two RAM words equal to 1, writes the successive sums 2, 3, 5, 8, … alternately to its two words, with the sums wrapping at DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| imem_addr | output | PC_W | Program counter, the program-memory read address |
| imem_data | input | 24 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | DADDR_W | Data-RAM address |
| dmem_we | output | 1 | Data-RAM write enable |
| dmem_wdata | output | DATA_W | Data-RAM write data |
| dmem_rdata | input | DATA_W | Data-RAM read data, one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A store is due in the second cycle of its instruction. In that cycle `dmem_we`, address and data are driven together, so the scoreboard monitor samples them at the falling edge of that same cycle and pops the next expected item. A load cannot be seen directly. It shows up in the value of a later store, so a loaded value or a C value is checked one store instruction later. The program counter is sampled on consecutive falling edges and must show each address twice before it advances. The halt state is checked after the halting instruction retires and again several cycles later, to confirm that nothing moved.

// File: rtl/opbank_pkg.sv
package opbank_pkg;

  localparam int INSTR_W = 24;
  localparam int OPC_W   = 6;
  localparam int FLD_W   = INSTR_W - OPC_W;

  localparam logic [OPC_W-1:0] OPC_LDA  = 6'h01;
  localparam logic [OPC_W-1:0] OPC_LDB  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_SETC = 6'h03;
  localparam logic [OPC_W-1:0] OPC_STC  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_SUM  = 6'h05;
  localparam logic [OPC_W-1:0] OPC_SHR  = 6'h06;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'h07;
  localparam logic [OPC_W-1:0] OPC_JGT  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_HALT = 6'h3F;

  typedef enum logic [1:0] {
    SRC_C   = 2'd0,
    SRC_SUM = 2'd1,
    SRC_SHR = 2'd2
  } wsrc_e;

  typedef enum logic {
    PH_ISSUE = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

  typedef struct packed {
    logic  ld_a;
    logic  ld_b;
    logic  set_c;
    logic  wr;
    logic  jmp;
    logic  jgt;
    logic  halt;
    wsrc_e src;
  } ctrl_t;

endpackage

// File: rtl/opbank_decode.sv
module opbank_decode
  import opbank_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl = '{ld_a: 1'b0, ld_b: 1'b0, set_c: 1'b0, wr: 1'b0,
             jmp: 1'b0, jgt: 1'b0, halt: 1'b0, src: SRC_C};
    case (opc)
      OPC_LDA:  ctrl.ld_a  = 1'b1;
      OPC_LDB:  ctrl.ld_b  = 1'b1;
      OPC_SETC: ctrl.set_c = 1'b1;
      OPC_STC: begin
        ctrl.wr  = 1'b1;
        ctrl.src = SRC_C;
      end
      OPC_SUM: begin
        ctrl.wr  = 1'b1;
        ctrl.src = SRC_SUM;
      end
      OPC_SHR: begin
        ctrl.wr  = 1'b1;
        ctrl.src = SRC_SHR;
      end
      OPC_JMP:  ctrl.jmp  = 1'b1;
      OPC_JGT:  ctrl.jgt  = 1'b1;
      OPC_HALT: ctrl.halt = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/opbank_results.sv
module opbank_results #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] shr,
  output logic              gt
);

  localparam int SHW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  // log-depth shifter: stage k shifts by 2**k when bit k of b is set
  logic [DATA_W-1:0] stage [0:SHW];
  logic              too_far;

  assign stage[0] = a;

  for (genvar k = 0; k < SHW; k++) begin : g_shift
    assign stage[k+1] = b[k] ? (stage[k] >> (2 ** k)) : stage[k];
  end

  assign too_far = |(b >> SHW);
  assign shr     = too_far ? '0 : stage[SHW];
  assign sum     = a + b;
  assign gt      = (a > b);

endmodule

// File: rtl/opbank_seq.sv
module opbank_seq
  import opbank_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            do_jmp,
  input  logic            do_jgt,
  input  logic            do_halt,
  input  logic            a_gt_b,
  input  logic [PC_W-1:0] target,
  output phase_e          phase,
  output logic [PC_W-1:0] pc,
  output logic            halted
);

  phase_e          phase_d;
  logic [PC_W-1:0] pc_d;
  logic            halted_d;
  logic            step_en;

  assign step_en = ~halted;

  always_comb begin
    phase_d  = phase;
    pc_d     = pc;
    halted_d = halted;
    if (step_en) begin
      case (phase)
        PH_ISSUE: phase_d = PH_EXEC;
        PH_EXEC: begin
          phase_d = PH_ISSUE;
          if (do_halt) begin
            halted_d = 1'b1;
          end else if (do_jmp || (do_jgt && a_gt_b)) begin
            pc_d = target;
          end else begin
            pc_d = pc + 1'b1;
          end
        end
        default: phase_d = PH_ISSUE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_ISSUE;
      pc     <= '0;
      halted <= 1'b0;
    end else if (step_en) begin
      phase  <= phase_d;
      pc     <= pc_d;
      halted <= halted_d;
    end
  end

endmodule

// File: rtl/opbank_core.sv
module opbank_core
  import opbank_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PC_W    = 8,
  parameter int DADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic               dmem_we,
  output logic [DATA_W-1:0]  dmem_wdata,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic               halted
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // state
  phase_e              phase_q;
  logic [INSTR_W-1:0]  ir_q;
  logic [DATA_W-1:0]   a_q, b_q, c_q;
  logic [PC_W-1:0]     pc_q;

  // decoded fields
  logic [OPC_W-1:0]    ir_opc;
  logic [FLD_W-1:0]    ir_fld;
  logic [FLD_W-1:0]    fetch_fld;
  logic [DATA_W-1:0]   c_imm;
  ctrl_t               ctrl;
  logic                in_exec;
  logic                ir_en, a_en, b_en, c_en;
  logic                unused_ir;

  // result bank
  logic [DATA_W-1:0]   res_sum, res_shr;
  logic                res_gt;

  assign ir_opc    = ir_q[INSTR_W-1:FLD_W];
  assign ir_fld    = ir_q[FLD_W-1:0];
  assign fetch_fld = imem_data[FLD_W-1:0];
  assign c_imm     = DATA_W'(ir_fld);
  assign in_exec   = (phase_q == PH_EXEC);
  assign unused_ir = ^ir_q;

  opbank_decode u_dec (
    .opc  (ir_opc),
    .ctrl (ctrl)
  );

  opbank_results #(.DATA_W(DATA_W)) u_res (
    .a   (a_q),
    .b   (b_q),
    .sum (res_sum),
    .shr (res_shr),
    .gt  (res_gt)
  );

  opbank_seq #(.PC_W(PC_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .do_jmp  (ctrl.jmp),
    .do_jgt  (ctrl.jgt),
    .do_halt (ctrl.halt),
    .a_gt_b  (res_gt),
    .target  (PC_W'(ir_fld)),
    .phase   (phase_q),
    .pc      (pc_q),
    .halted  (halted)
  );

  // clock enables
  assign ir_en = ~in_exec & ~halted;
  assign a_en  = in_exec & ctrl.ld_a;
  assign b_en  = in_exec & ctrl.ld_b;
  assign c_en  = in_exec & ctrl.set_c;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ir_q <= '0;
    else if (ir_en)  ir_q <= imem_data;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) a_q <= '0;
    else if (a_en)   a_q <= dmem_rdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) b_q <= '0;
    else if (b_en)   b_q <= dmem_rdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) c_q <= '0;
    else if (c_en)   c_q <= c_imm;
  end

  // memory ports
  assign imem_addr = pc_q;
  assign dmem_addr = in_exec ? DADDR_W'(ir_fld) : DADDR_W'(fetch_fld);
  assign dmem_we   = in_exec & ctrl.wr & ~halted;

  always_comb begin
    case (ctrl.src)
      SRC_C:   dmem_wdata = c_q;
      SRC_SUM: dmem_wdata = res_sum;
      SRC_SHR: dmem_wdata = res_shr;
      default: dmem_wdata = '0;
    endcase
  end

endmodule

// File: rtl/opbank_core_chk.sv
module opbank_core_chk
  import opbank_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PC_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   imem_addr,
  input logic              dmem_we,
  input logic [DATA_W-1:0] dmem_wdata,
  input logic [DATA_W-1:0] dmem_rdata,
  input logic              halted,
  input logic              in_exec,
  input logic [OPC_W-1:0]  opc,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic [DATA_W-1:0] c,
  input logic [DATA_W-1:0] imm
);

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (a == '0 && b == '0 && c == '0 && imem_addr == '0 && !halted)); // R1

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> !dmem_we); // R2

  AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && opc == OPC_LDA) |=> (a == $past(dmem_rdata))); // R3

  AST_SET_C: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && opc == OPC_SETC) |=> (c == $past(imm))); // R4

  AST_SHR_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_we && opc == OPC_SHR && b >= DATA_W[DATA_W-1:0]) |-> (dmem_wdata == '0)); // R6

  AST_JGT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && !halted && opc == OPC_JGT && a <= b) |=>
      (imem_addr == PC_W'($past(imem_addr) + 1'b1))); // R8

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(imem_addr))); // R9

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !dmem_we); // R9

endmodule

bind opbank_core opbank_core_chk #(
  .DATA_W (DATA_W),
  .PC_W   (PC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .imem_addr  (imem_addr),
  .dmem_we    (dmem_we),
  .dmem_wdata (dmem_wdata),
  .dmem_rdata (dmem_rdata),
  .halted     (halted),
  .in_exec    (in_exec),
  .opc        (ir_opc),
  .a          (a_q),
  .b          (b_q),
  .c          (c_q),
  .imm        (c_imm)
);

// File: tb/sim_opbank_core.sv
module sim_opbank_core;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int PC_W       = 8;
  localparam int DADDR_W    = 10;

  logic               clk;
  logic               rst_n;
  logic [PC_W-1:0]    imem_addr;
  logic [23:0]        imem_data;
  logic [DADDR_W-1:0] dmem_addr;
  logic               dmem_we;
  logic [DATA_W-1:0]  dmem_wdata;
  logic [DATA_W-1:0]  dmem_rdata;
  logic               halted;

  int total = 0;
  int bad   = 0;

  logic [23:0]       rom [0:(1<<PC_W)-1];
  logic [DATA_W-1:0] ram [0:(1<<DADDR_W)-1];

  int               exp_addr [$];
  logic [DATA_W-1:0] exp_data [$];
  string            exp_tag  [$];

  opbank_core #(.DATA_W(DATA_W), .PC_W(PC_W), .DADDR_W(DADDR_W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .halted     (halted)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_data = rom[imem_addr];

  always @(posedge clk) begin
    if (dmem_we) ram[dmem_addr] <= dmem_wdata;
    dmem_rdata <= ram[dmem_addr];
  end

  function automatic logic [23:0] ins(input logic [5:0] op, input int fld);
    return {op, 18'(fld)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_wr(input int addr, input logic [DATA_W-1:0] data, input string tag);
    exp_addr.push_back(addr);
    exp_data.push_back(data);
    exp_tag.push_back(tag);
  endtask

  task automatic clear_rom();
    for (int i = 0; i < (1<<PC_W); i++) rom[i] = 24'h0;
  endtask

  // monitor: every write is compared with the next expected item
  always @(negedge clk) begin
    if (rst_n && dmem_we) begin
      if (exp_addr.size() == 0) begin
        check(1'b0, "R7 R9 R10", "unexpected write addr", longint'(dmem_addr), -1);
      end else begin
        int               ea;
        logic [DATA_W-1:0] ed;
        string            et;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        et = exp_tag.pop_front();
        check(int'(dmem_addr) == ea, et, "write address", longint'(dmem_addr), longint'(ea));
        check(dmem_wdata == ed, et, "write data", longint'(dmem_wdata), longint'(ed));
      end
    end
  end

  task automatic wait_drain(input int maxc, input string req);
    int n;
    n = 0;
    while (exp_addr.size() != 0 && n < maxc) begin
      @(negedge clk);
      n++;
    end
    check(exp_addr.size() == 0, req, "pending writes", longint'(exp_addr.size()), 0);
  endtask

  task automatic wait_halt(input int maxc);
    int n;
    n = 0;
    while (!halted && n < maxc) begin
      @(negedge clk);
      n++;
    end
    check(halted == 1'b1, "R9", "halted after program", longint'(halted), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] fa, fb;
    logic [PC_W-1:0]   seen [0:5];
    int                n;

    rst_n = 1'b0;
    clear_rom();

    // ---- Fibonacci loop (R11, R7, R8 taken and not taken) ----
    rom[0]  = ins(6'h03, 1);
    rom[1]  = ins(6'h04, 0);
    rom[2]  = ins(6'h01, 0);
    rom[3]  = ins(6'h04, 1);
    rom[4]  = ins(6'h02, 1);
    rom[5]  = ins(6'h08, 9);
    rom[6]  = ins(6'h05, 0);
    rom[7]  = ins(6'h01, 0);
    rom[8]  = ins(6'h07, 5);
    rom[9]  = ins(6'h05, 1);
    rom[10] = ins(6'h02, 1);
    rom[11] = ins(6'h07, 5);

    repeat (3) @(negedge clk);
    check(imem_addr == '0, "R1", "pc in reset", longint'(imem_addr), 0);
    check(halted == 1'b0, "R1", "halted in reset", longint'(halted), 0);
    check(dmem_we == 1'b0, "R1", "write enable in reset", longint'(dmem_we), 0);

    push_wr(0, 16'd1, "R4 R11");
    push_wr(1, 16'd1, "R4 R11");
    fa = 16'd1;
    fb = 16'd1;
    for (int k = 0; k < 26; k++) begin
      if (fa > fb) begin
        fb = fa + fb;
        push_wr(1, fb, "R11");
      end else begin
        fa = fa + fb;
        push_wr(0, fa, "R11");
      end
    end
    @(negedge clk) rst_n = 1'b1;
    wait_drain(2000, "R11");
    @(negedge clk) rst_n = 1'b0;

    // ---- stores right after reset read zero registers (R1) ----
    clear_rom();
    rom[0] = ins(6'h05, 5);
    rom[1] = ins(6'h04, 6);
    rom[2] = ins(6'h06, 7);
    rom[3] = ins(6'h3F, 0);
    push_wr(5, 16'h0, "R1");
    push_wr(6, 16'h0, "R1");
    push_wr(7, 16'h0, "R1");
    repeat (2) @(negedge clk);
    check(imem_addr == '0, "R1", "pc after mid-run reset", longint'(imem_addr), 0);
    rst_n = 1'b1;
    wait_halt(200);
    wait_drain(50, "R1");
    @(negedge clk) rst_n = 1'b0;

    // ---- operation mix ----
    clear_rom();
    rom[0]  = ins(6'h03, 16'hFFF0);
    rom[1]  = ins(6'h04, 10);
    rom[2]  = ins(6'h03, 16'h0020);
    rom[3]  = ins(6'h04, 11);
    rom[4]  = ins(6'h01, 10);
    rom[5]  = ins(6'h02, 11);
    rom[6]  = ins(6'h05, 12);
    rom[7]  = ins(6'h03, 4);
    rom[8]  = ins(6'h04, 13);
    rom[9]  = ins(6'h02, 13);
    rom[10] = ins(6'h06, 14);
    rom[11] = ins(6'h03, 16);
    rom[12] = ins(6'h04, 15);
    rom[13] = ins(6'h02, 15);
    rom[14] = ins(6'h06, 16);
    rom[15] = ins(6'h09, 5);
    rom[16] = ins(6'h01, 15);
    rom[17] = ins(6'h08, 40);
    rom[18] = ins(6'h03, 16'h1234);
    rom[19] = ins(6'h04, 20);
    rom[20] = ins(6'h07, 23);
    rom[21] = ins(6'h03, 16'h0BAD);
    rom[22] = ins(6'h04, 21);
    rom[23] = ins(6'h05, 22);
    rom[24] = ins(6'h3F, 0);
    rom[25] = ins(6'h04, 23);
    rom[40] = ins(6'h03, 16'h0BAD);
    rom[41] = ins(6'h04, 21);

    push_wr(10, 16'hFFF0, "R4");
    push_wr(11, 16'h0020, "R4");
    push_wr(12, 16'h0010, "R3 R5");
    push_wr(13, 16'h0004, "R4");
    push_wr(14, 16'h0FFF, "R6");
    push_wr(15, 16'h0010, "R4");
    push_wr(16, 16'h0000, "R6");
    push_wr(20, 16'h1234, "R8");
    push_wr(22, 16'h0020, "R7 R10");

    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (imem_addr == '0 && n < 50) begin
      @(negedge clk);
      n++;
    end
    seen[0] = imem_addr;
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      seen[i] = imem_addr;
    end
    for (int i = 0; i < 6; i++) begin
      check(seen[i] == PC_W'(1 + i/2), "R2", "pc held two cycles",
            longint'(seen[i]), longint'(1 + i/2));
    end

    wait_halt(500);
    wait_drain(50, "R9");
    check(imem_addr == PC_W'(24), "R9", "pc at halt", longint'(imem_addr), 24);
    repeat (8) @(negedge clk);
    check(imem_addr == PC_W'(24), "R9", "pc frozen after halt", longint'(imem_addr), 24);
    check(halted == 1'b1, "R9", "halted stays high", longint'(halted), 1);
    check(dmem_we == 1'b0, "R9", "no write while halted", longint'(dmem_we), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule